// File: doc/BRIEF.md
# Nibble-Serial Chip-Boundary Link

This block carries full-width datapath words across a chip edge on a narrow 4-bit connection. Each chip boundary port holds one transmit engine and one receive engine. A configuration input selects which of the two is active, so one pin group can be used in either direction. The direction is set before reset is released and does not change while the array runs.

On the parallel side the block uses the same valid/ready handshake as an on-chip neighbour link, so the attached processing unit never sees the narrow link. A word has 34 bits: 32 data bits and 2 status bits. It is cut into 4-bit beats, least significant first. Each beat is bundled with a request line that toggles once per beat. The far end answers each beat by toggling an acknowledge line, so the link is paced by handshakes and has no fixed timing. Request and acknowledge pass through synchronizers at the receiving end of each wire. This allows the two chips to run from unrelated clocks.

Top module: `nib_link_port`

## Requirements
- R1: While reset is held, and after it is released, `out_valid_o`, `ser_req_o`, `ser_data_o` and `ser_ack_o` are all 0. In transmit mode `in_ready_o` is 1 after reset.
- R2: An accepted word `w` is sent as 9 beats. Beat k (k = 0..8) carries bits `w[4k+3:4k]`, so beat 0 holds bits 3..0. Bits 3..2 of beat 8 lie beyond the 34-bit word and are driven 0.
- R3: Each beat is announced by one toggle of `ser_req_o`, and `ser_data_o` changes only together with such a toggle. A new toggle happens only when `ser_ack_i` already equals the current `ser_req_o` level, which means the previous beat has been acknowledged.
- R4: The transmitter takes a new word only after the last beat of the previous word has been acknowledged. From the accepting edge until that point, `in_ready_o` is 0.
- R5: The receiver asserts `out_valid_o` only after the ninth beat of a word has arrived. `out_word_o` then equals the transmitted word, status bits 33..32 included. The pad bits of the last beat are discarded.
- R6: While `out_valid_o` is 1 and `out_ready_i` is 0, both `out_valid_o` and `out_word_o` hold. During that time the receiver does not acknowledge any further beat, so `ser_ack_o` stays constant.
- R7: With `dir_tx_i` = 1, `out_valid_o` and `ser_ack_o` stay 0. With `dir_tx_i` = 0, `in_ready_o`, `ser_req_o` and `ser_data_o` stay 0. `dir_tx_i` is static whenever `rst_ni` is high.
- R8: Between a transmitting end and a receiving end, every word comes out exactly once and in the order it was accepted, whatever stalls occur on either parallel side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_tx_i | input | 1 | Direction select: 1 = transmit, 0 = receive |
| in_valid_i | input | 1 | Parallel input word valid |
| in_ready_o | output | 1 | Transmitter can accept a word |
| in_word_i | input | WORD_W | Parallel word to send (bits 33..32 are status) |
| out_valid_o | output | 1 | Received word valid |
| out_ready_i | input | 1 | Consumer takes the received word |
| out_word_o | output | WORD_W | Received word |
| ser_req_o | output | 1 | Outgoing beat request (toggle) |
| ser_data_o | output | NIB_W | Outgoing beat data |
| ser_ack_i | input | 1 | Acknowledge from the far receiver (toggle) |
| ser_req_i | input | 1 | Incoming beat request (toggle) |
| ser_data_i | input | NIB_W | Incoming beat data |
| ser_ack_o | output | 1 | Acknowledge to the far transmitter (toggle) |

## Verification
The assertions check the following on every cycle:
- both direction quiet rules;
- data changing only with a request toggle;
- the zero pad on the ninth beat;
- `in_ready_o` never rising in the middle of a word;
- the held output word, and the withheld acknowledge under back-pressure.

The bench scenarios alone can show the rest, because each spans two link ends:
- that the beats appear in least-significant-first order, with the right contents;
- that each toggle waits for the previous acknowledge;
- that status bits survive the trip;
- that words arrive in order with no loss under random stalls, in both direction settings.

// File: rtl/nib_link_pkg.sv
package nib_link_pkg;

  localparam int unsigned DEF_WORD_W = 34;
  localparam int unsigned DEF_NIB_W  = 4;
  localparam int unsigned DEF_SYNC   = 2;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_BUSY = 1'b1
  } tx_state_e;

  function automatic int unsigned beat_count(int unsigned word_w, int unsigned nib_w);
    return (word_w + nib_w - 1) / nib_w;
  endfunction

endpackage

// File: rtl/nib_sync.sv
module nib_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2+1-1:0], d_i} >> 0;
      end
      assign q_o = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/nib_tx.sv
module nib_tx
  import nib_link_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned NIB_W  = DEF_NIB_W,
  parameter int unsigned SYNC   = DEF_SYNC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_word_i,
  output logic              req_o,
  output logic [NIB_W-1:0]  data_o,
  input  logic              ack_i
);

  localparam int unsigned BEATS = beat_count(WORD_W, NIB_W);
  localparam int unsigned PAD_W = BEATS * NIB_W;
  localparam int unsigned CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

  tx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PAD_W-1:0] shift_q;
  logic             req_q;
  logic             ack_s;

  nib_sync #(.STAGES(SYNC)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_i),
    .q_o   (ack_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      req_q   <= 1'b0;
    end else if (!en_i) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      req_q   <= 1'b0;
    end else begin
      unique case (state_q)
        TX_IDLE: begin
          if (in_valid_i) begin
            shift_q <= PAD_W'(in_word_i);
            req_q   <= ~req_q;
            cnt_q   <= '0;
            state_q <= TX_BUSY;
          end
        end
        TX_BUSY: begin
          // previous beat acknowledged once the synced ack matches req
          if (ack_s == req_q) begin
            if (cnt_q == LAST) begin
              state_q <= TX_IDLE;
            end else begin
              shift_q <= shift_q >> NIB_W;
              req_q   <= ~req_q;
              cnt_q   <= cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign in_ready_o = en_i && (state_q == TX_IDLE);
  assign req_o      = req_q;
  assign data_o     = shift_q[NIB_W-1:0];

endmodule

// File: rtl/nib_rx.sv
module nib_rx
  import nib_link_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned NIB_W  = DEF_NIB_W,
  parameter int unsigned SYNC   = DEF_SYNC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              req_i,
  input  logic [NIB_W-1:0]  data_i,
  output logic              ack_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_word_o
);

  localparam int unsigned BEATS = beat_count(WORD_W, NIB_W);
  localparam int unsigned PAD_W = BEATS * NIB_W;
  localparam int unsigned CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

  logic             req_s;
  logic             ack_q;
  logic             valid_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PAD_W-1:0] buf_q;
  logic             take;

  nib_sync #(.STAGES(SYNC)) u_req_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_i),
    .q_o   (req_s)
  );

  // a held word blocks the next beat: no ack until the consumer drains it
  assign take = (req_s != ack_q) && !valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      valid_q <= 1'b0;
      cnt_q   <= '0;
      buf_q   <= '0;
    end else if (!en_i) begin
      ack_q   <= 1'b0;
      valid_q <= 1'b0;
      cnt_q   <= '0;
      buf_q   <= '0;
    end else begin
      if (valid_q && out_ready_i) valid_q <= 1'b0;
      if (take) begin
        buf_q <= {data_i, buf_q[PAD_W-1:NIB_W]};
        ack_q <= req_s;
        if (cnt_q == LAST) begin
          cnt_q   <= '0;
          valid_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign ack_o       = ack_q;
  assign out_valid_o = valid_q;
  assign out_word_o  = buf_q[WORD_W-1:0];

endmodule

// File: rtl/nib_link_port.sv
module nib_link_port
  import nib_link_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned NIB_W  = DEF_NIB_W,
  parameter int unsigned SYNC   = DEF_SYNC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_tx_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_word_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_word_o,
  output logic              ser_req_o,
  output logic [NIB_W-1:0]  ser_data_o,
  input  logic              ser_ack_i,
  input  logic              ser_req_i,
  input  logic [NIB_W-1:0]  ser_data_i,
  output logic              ser_ack_o
);

  logic             tx_req;
  logic [NIB_W-1:0] tx_data;
  logic             rx_ack;

  nib_tx #(.WORD_W(WORD_W), .NIB_W(NIB_W), .SYNC(SYNC)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (dir_tx_i),
    .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o),
    .in_word_i (in_word_i),
    .req_o     (tx_req),
    .data_o    (tx_data),
    .ack_i     (ser_ack_i)
  );

  nib_rx #(.WORD_W(WORD_W), .NIB_W(NIB_W), .SYNC(SYNC)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (!dir_tx_i),
    .req_i      (ser_req_i),
    .data_i     (ser_data_i),
    .ack_o      (rx_ack),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .out_word_o (out_word_o)
  );

  assign ser_req_o  = tx_req;
  assign ser_data_o = tx_data;
  assign ser_ack_o  = rx_ack;

endmodule

// File: rtl/nib_link_chk.sv
module nib_link_chk
  import nib_link_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned NIB_W  = DEF_NIB_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dir_tx_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [WORD_W-1:0] out_word_o,
  input logic              ser_req_o,
  input logic [NIB_W-1:0]  ser_data_o,
  input logic              ser_ack_o
);

  localparam int unsigned BEATS  = beat_count(WORD_W, NIB_W);
  localparam int unsigned LAST_W = WORD_W - (BEATS - 1) * NIB_W;
  localparam int unsigned IDX_W  = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [IDX_W-1:0] idx_q;
  logic             req_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      req_d <= 1'b0;
    end else begin
      req_d <= ser_req_o;
      if (ser_req_o != req_d)
        idx_q <= (idx_q == IDX_W'(BEATS - 1)) ? '0 : idx_q + 1'b1;
    end
  end

  AST_TX_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> (idx_q == '0)); // R4

  AST_DATA_WITH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_req_o == req_d) |-> $stable(ser_data_o)); // R3

  generate
    if (LAST_W < NIB_W) begin : g_pad
      AST_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((ser_req_o != req_d) && (idx_q == IDX_W'(BEATS - 1))) |->
          ((ser_data_o >> LAST_W) == '0)); // R2
    end
  endgenerate

  AST_VALID_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> (ser_ack_o != $past(ser_ack_o))); // R5

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_word_o))); // R6

  AST_ACK_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_ack_o != $past(ser_ack_o)) |-> !$past(out_valid_o)); // R6

  AST_DIR_TX_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_tx_i |-> (!out_valid_o && !ser_ack_o)); // R7

  AST_DIR_RX_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_tx_i |-> (!in_ready_o && !ser_req_o && (ser_data_o == '0))); // R7

endmodule

bind nib_link_port nib_link_chk #(.WORD_W(WORD_W), .NIB_W(NIB_W)) u_chk (.*);

// File: tb/nib_link_port_test.sv
`timescale 1ns/1ps
module nib_link_port_test;

  localparam int W  = 34;
  localparam int NB = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 0;

  bit phase_a;
  logic a_dir, b_dir;
  logic snd_valid = 1'b0;
  logic [W-1:0] snd_word = '0;
  logic rcv_ready = 1'b0;

  logic a_in_valid, a_in_ready, a_out_valid, a_out_ready;
  logic b_in_valid, b_in_ready, b_out_valid, b_out_ready;
  logic [W-1:0] a_out_word, b_out_word;
  logic a_req, a_ack, b_req, b_ack;
  logic [3:0] a_data, b_data;

  assign a_in_valid  = phase_a & snd_valid;
  assign b_in_valid  = !phase_a & snd_valid;
  assign a_out_ready = !phase_a & rcv_ready;
  assign b_out_ready = phase_a & rcv_ready;

  nib_link_port uut (
    .clk_i(clk), .rst_ni(rst_n), .dir_tx_i(a_dir),
    .in_valid_i(a_in_valid), .in_ready_o(a_in_ready), .in_word_i(snd_word),
    .out_valid_o(a_out_valid), .out_ready_i(a_out_ready), .out_word_o(a_out_word),
    .ser_req_o(a_req), .ser_data_o(a_data), .ser_ack_i(b_ack),
    .ser_req_i(b_req), .ser_data_i(b_data), .ser_ack_o(a_ack)
  );

  nib_link_port peer (
    .clk_i(clk), .rst_ni(rst_n), .dir_tx_i(b_dir),
    .in_valid_i(b_in_valid), .in_ready_o(b_in_ready), .in_word_i(snd_word),
    .out_valid_o(b_out_valid), .out_ready_i(b_out_ready), .out_word_o(b_out_word),
    .ser_req_o(b_req), .ser_data_o(b_data), .ser_ack_i(a_ack),
    .ser_req_i(a_req), .ser_data_i(a_data), .ser_ack_o(b_ack)
  );

  wire          snd_ready = phase_a ? a_in_ready : b_in_ready;
  wire          rcv_valid = phase_a ? b_out_valid : a_out_valid;
  wire [W-1:0]  rcv_word  = phase_a ? b_out_word : a_out_word;
  wire          link_req  = phase_a ? a_req : b_req;
  wire [3:0]    link_data = phase_a ? a_data : b_data;
  wire          link_ack  = phase_a ? b_ack : a_ack;

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_nib(logic [W-1:0] w, int k);
    logic [4*NB-1:0] p;
    p = {{(4*NB-W){1'b0}}, w};
    return p[4*k +: 4];
  endfunction

  function automatic logic [W-1:0] gen_word(int i);
    logic [63:0] r;
    case (i)
      0: return '0;
      1: return '1;
      2: return 34'h2_0000_0000;
      3: return 34'h1_5555_5555;
      4: return 34'h2_AAAA_AAAA;
      default: begin
        r = {$urandom(), $urandom()};
        return r[W-1:0];
      end
    endcase
  endfunction

  logic [W-1:0] exp_q[$];
  logic [W-1:0] wire_q[$];
  int  target = 0, nsent = 0, nrecv = 0;
  bit  traffic_on = 0, mon_on = 0, hold = 0, take_pend = 0;
  logic last_req = 1'b0;
  logic [3:0] last_data = '0;
  int  mon_idx = 0;

  // sender and receiver drive at negedge; decisions apply at the next posedge
  always @(negedge clk) begin
    if (traffic_on) begin
      if (take_pend) begin snd_valid = 1'b0; take_pend = 0; end
      if (!snd_valid && nsent < target && ($urandom() % 4) != 0) begin
        snd_valid = 1'b1;
        snd_word  = gen_word(nsent);
        nsent++;
      end
      if (snd_valid && snd_ready) begin
        exp_q.push_back(snd_word);
        wire_q.push_back(snd_word);
        take_pend = 1;
      end
      rcv_ready = hold ? 1'b0 : (($urandom() % 3) != 0);
      if (rcv_valid && rcv_ready) begin
        if (exp_q.size() == 0) chk("R8 extra word", 36'(rcv_word), 36'h0);
        else chk("R5 R8 word", 36'(rcv_word), 36'(exp_q.pop_front()));
        nrecv++;
      end
    end
  end

  // wire monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (link_req != last_req) begin
        chk("R3 ack before toggle", 36'(link_ack), 36'(last_req));
        if (wire_q.size() == 0) chk("R2 beat without word", 36'h1, 36'h0);
        else begin
          chk($sformatf("R2 beat %0d", mon_idx), 36'(link_data), 36'(exp_nib(wire_q[0], mon_idx)));
          mon_idx++;
          if (mon_idx == NB) begin
            void'(wire_q.pop_front());
            mon_idx = 0;
          end
        end
      end else begin
        chk("R3 data stable", 36'(link_data), 36'(last_data));
      end
      if (mon_idx != 0) chk("R4 ready mid word", 36'(snd_ready), 36'h0);
      if (phase_a) begin
        chk("R7 quiet", {a_out_valid, a_ack, b_in_ready, b_req, b_data}, '0);
      end else begin
        chk("R7 quiet", {b_out_valid, b_ack, a_in_ready, a_req, a_data}, '0);
      end
      last_req  = link_req;
      last_data = link_data;
    end
  end

  task automatic wait_drain();
    while (nrecv < target) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R8 queue empty", 36'(exp_q.size()), 36'h0);
  endtask

  task automatic run_phase(bit pa);
    logic         ack0;
    logic [W-1:0] w0;
    traffic_on = 0; mon_on = 0; hold = 0; take_pend = 0;
    snd_valid = 1'b0; rcv_ready = 1'b0;
    rst_n = 1'b0;
    phase_a = pa;
    a_dir = pa; b_dir = !pa;
    exp_q.delete(); wire_q.delete();
    nsent = 0; nrecv = 0; target = 0; mon_idx = 0;
    last_req = 1'b0; last_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", {a_out_valid, b_out_valid, a_req, b_req, a_ack, b_ack, a_data, b_data}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {a_out_valid, b_out_valid, a_req, b_req, a_ack, b_ack, a_data, b_data}, '0);
    chk("R1 ready", 36'(snd_ready), 36'h1);
    mon_on = 1;
    target = 110;
    traffic_on = 1;
    wait_drain();
    // back-pressure: hold one word, queue another behind it
    hold = 1;
    target += 2;
    while (!rcv_valid) @(negedge clk);
    ack0 = link_ack;
    w0   = rcv_word;
    repeat (60) @(negedge clk);
    chk("R6 valid held", 36'(rcv_valid), 36'h1);
    chk("R6 word held", 36'(rcv_word), 36'(w0));
    chk("R6 word value", 36'(rcv_word), 36'(exp_q[0]));
    chk("R6 ack held", 36'(link_ack), 36'(ack0));
    chk("R4 sender stalled", 36'(snd_ready), 36'h0);
    hold = 0;
    wait_drain();
    traffic_on = 0;
    mon_on = 0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    phase_a = 1; a_dir = 1'b1; b_dir = 1'b0;
    run_phase(1'b1);
    run_phase(1'b0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R8 act=%0d exp=%0d", nrecv, target);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule